// File: doc/BRIEF.md
# Watchdog Timer with Selectable Clearing

This block is a watchdog timer. It counts ticks from one of two tick sources: a tick derived from an on-chip RC oscillator, or a tick from the instruction clock. It can also be switched off completely. If software does not clear the watchdog in time, the block emits a single-cycle reset request. It also raises a sticky flag that records that a time-out happened. All logic runs on one system clock. Each tick source arrives as a one-cycle enable qualified on that clock.

The time-out is built from two counters:
- a free-running prescaler of `PRE_BITS` bits, which software never clears;
- a small post-counter that a clear does reset.

Because the prescaler keeps running, a time-out lands somewhere in a window one power of two wide. Clearing works in one of two modes. In single mode, one clear strobe is enough. In dual mode, two distinct strobes must both be seen before the counter clears, so one stray write cannot keep the watchdog quiet.

Configuration (source, range, clear mode) is captured only while reset is held. Changes to the configuration inputs during operation have no effect.

Top module: `watchdog_timer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `wdt_rst_o` and `to_flag_o` are 0.
- R2: The captured `cfg_src` selects the count source: 2'b01 counts `rc_tick` cycles, 2'b10 counts `instr_tick` cycles, and 2'b00 or 2'b11 disables counting, so that no time-out ever occurs. A tick on the unselected source is not counted.
- R3: With `cfg_range` = r and the post-counter cleared, the watchdog times out on the 2^(r+1)-th prescaler wrap. The prescaler wraps once every 2^PRE_BITS counted ticks. Starting from reset with a tick every cycle, the first time-out therefore comes on counted tick 2^(r+1+PRE_BITS).
- R4: `wdt_rst_o` is high for exactly one cycle per time-out. The counter then restarts, so with steady ticks the next time-out comes after the same number of ticks again.
- R5: `to_flag_o` goes to 1 in the same cycle as the first `wdt_rst_o` pulse and stays 1 until reset.
- R6: In single mode (`cfg_dual` = 0), a cycle with `clr_a` or `clr_b` high resets the post-counter to zero.
- R7: In dual mode (`cfg_dual` = 1), the post-counter is reset only in the cycle where both strobes have been seen since the last clear. The two strobes may come in the same cycle or in any order. One strobe alone, even if repeated, does not clear the counter.
- R8: In dual mode, a clear discards both pending strobe records. After a clear, a lone strobe of either kind does not clear the counter again.
- R9: A clear never resets the prescaler, so the time to the next time-out after a clear depends on the prescaler phase.
- R10: If a clear and the final prescaler wrap fall in the same cycle, the clear wins: no pulse is produced and the count restarts from zero.
- R11: Changes on `cfg_src`, `cfg_range` or `cfg_dual` while `rst` is low have no effect on behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset; also captures configuration |
| rc_tick | input | 1 | One-cycle tick from the RC oscillator domain |
| instr_tick | input | 1 | One-cycle tick from the instruction clock |
| cfg_src | input | 2 | Count source: 01 RC, 10 instruction, 00/11 disabled |
| cfg_range | input | 2 | Time-out range select r (2^(r+1) prescaler wraps) |
| cfg_dual | input | 1 | 1 selects the two-strobe clear handshake |
| clr_a | input | 1 | First clear strobe |
| clr_b | input | 1 | Second clear strobe |
| wdt_rst_o | output | 1 | One-cycle time-out reset request |
| to_flag_o | output | 1 | Sticky time-out status |

## Verification
The assertions check the following on every cycle:
- the time-out pulse is one cycle wide;
- the sticky flag never falls;
- a disabled source never produces a pulse;
- a qualified clear empties the post-counter and the pending strobe records;
- a lone first strobe in dual mode leaves the count untouched;
- the captured configuration never moves outside reset.

Some properties depend on the prescaler phase and on a whole sequence of strobes, so only the bench scenarios can show them. These are the exact time-out latency for each range, the later time-out caused by a clear that leaves the prescaler running, the clear winning over a coinciding wrap, and stale strobes having no effect after a dual-mode clear.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int RANGE_W = 2;

    typedef enum logic [1:0] {
        SRC_NONE     = 2'd0,
        SRC_RC       = 2'd1,
        SRC_INSTR    = 2'd2,
        SRC_NONE_ALT = 2'd3
    } src_sel_e;

    typedef struct packed {
        src_sel_e             src;
        logic [RANGE_W-1:0]   range;
        logic                 dual;
    } wdt_cfg_t;

    // number of prescaler wraps that make up one time-out
    function automatic int unsigned wraps_for_range(input logic [RANGE_W-1:0] r);
        return 32'd1 << (32'(r) + 32'd1);
    endfunction

    function automatic logic pick_tick(input src_sel_e s, input logic rc, input logic ins);
        logic t;
        unique case (s)
            SRC_RC:    t = rc;
            SRC_INSTR: t = ins;
            default:   t = 1'b0;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale
    import wdt_pkg::*;
#(
    parameter int PRE_BITS = 12
) (
    input  logic     clk,
    input  logic     rst,
    input  src_sel_e src,
    input  logic     rc_tick,
    input  logic     instr_tick,
    output logic     wrap
);
    logic [PRE_BITS-1:0] pre_q;
    logic                tick;

    assign tick = pick_tick(src, rc_tick, instr_tick);
    assign wrap = tick & (&pre_q);

    // free running: only reset touches it, never a software clear
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q <= '0;
        end else if (tick) begin
            pre_q <= pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_clear.sv
module wdt_clear (
    input  logic       clk,
    input  logic       rst,
    input  logic       dual,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic       clr_go,
    output logic [1:0] pend
);
    logic pend_a_q, pend_b_q;

    always_comb begin
        if (dual) begin
            clr_go = (clr_a | pend_a_q) & (clr_b | pend_b_q);
        end else begin
            clr_go = clr_a | clr_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !dual || clr_go) begin
            pend_a_q <= 1'b0;
            pend_b_q <= 1'b0;
        end else begin
            pend_a_q <= pend_a_q | clr_a;
            pend_b_q <= pend_b_q | clr_b;
        end
    end

    assign pend = {pend_b_q, pend_a_q};
endmodule

// File: rtl/wdt_post.sv
module wdt_post
    import wdt_pkg::*;
#(
    parameter int POST_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wrap,
    input  logic               clr_go,
    input  logic [RANGE_W-1:0] range,
    output logic               pulse,
    output logic               flag,
    output logic [POST_W-1:0]  cnt
);
    logic [POST_W-1:0] lim;
    logic [POST_W-1:0] cnt_q;
    logic              pulse_q, flag_q;

    assign lim = POST_W'(wraps_for_range(range) - 32'd1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            pulse_q <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (clr_go) begin
                cnt_q <= '0;
            end else if (wrap) begin
                if (cnt_q == lim) begin
                    cnt_q   <= '0;
                    pulse_q <= 1'b1;
                    flag_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    assign pulse = pulse_q;
    assign flag  = flag_q;
    assign cnt   = cnt_q;

    // R4: a time-out request lasts one cycle only
    a_r4_one_cycle: assert property (@(posedge clk) disable iff (rst)
        pulse_q |=> !pulse_q);
    // R4: the count restarts when the pulse is issued
    a_r4_restart: assert property (@(posedge clk) disable iff (rst)
        pulse_q |-> cnt_q == '0);
    // R5: the status flag never falls outside reset
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        flag_q |=> flag_q);
endmodule

// File: rtl/watchdog_timer.sv
module watchdog_timer
    import wdt_pkg::*;
#(
    parameter int PRE_BITS = 12
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       rc_tick,
    input  logic       instr_tick,
    input  logic [1:0] cfg_src,
    input  logic [1:0] cfg_range,
    input  logic       cfg_dual,
    input  logic       clr_a,
    input  logic       clr_b,
    output logic       wdt_rst_o,
    output logic       to_flag_o
);
    localparam int POST_W = 1 << RANGE_W;

    wdt_cfg_t          cfg_q;
    logic              wrap;
    logic              clr_go;
    logic [1:0]        pend;
    logic [POST_W-1:0] post_cnt;

    // configuration is captured only while reset is held
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '{src: src_sel_e'(cfg_src), range: cfg_range, dual: cfg_dual};
        end
    end

    wdt_prescale #(.PRE_BITS(PRE_BITS)) u_pre (
        .clk        (clk),
        .rst        (rst),
        .src        (cfg_q.src),
        .rc_tick    (rc_tick),
        .instr_tick (instr_tick),
        .wrap       (wrap)
    );

    wdt_clear u_clr (
        .clk    (clk),
        .rst    (rst),
        .dual   (cfg_q.dual),
        .clr_a  (clr_a),
        .clr_b  (clr_b),
        .clr_go (clr_go),
        .pend   (pend)
    );

    wdt_post #(.POST_W(POST_W)) u_post (
        .clk    (clk),
        .rst    (rst),
        .wrap   (wrap),
        .clr_go (clr_go),
        .range  (cfg_q.range),
        .pulse  (wdt_rst_o),
        .flag   (to_flag_o),
        .cnt    (post_cnt)
    );

    // R2: a disabled source never times out
    a_r2_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src == SRC_NONE || cfg_q.src == SRC_NONE_ALT) |-> !wdt_rst_o);
    // R6: a qualified clear empties the post-counter
    a_r6_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr_go |=> post_cnt == '0);
    // R7: a lone first strobe in dual mode leaves the count alone
    a_r7_lone_strobe: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.dual && clr_a && !clr_b && !pend[1] && !wrap) |=> post_cnt == $past(post_cnt));
    // R8: a dual-mode clear discards pending strobes
    a_r8_pend_drop: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.dual && clr_go) |=> pend == 2'b00);
    // R11: captured configuration holds outside reset
    a_r11_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(cfg_q));
endmodule

// File: tb/tb_watchdog_timer.sv
`timescale 1ns/1ps
module tb_watchdog_timer;
    localparam int PB   = 4;
    localparam int PMOD = 1 << PB;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic rc_tick = 1'b0, instr_tick = 1'b0;
    logic [1:0] cfg_src = 2'd1, cfg_range = 2'd0;
    logic cfg_dual = 1'b0;
    logic clr_a = 1'b0, clr_b = 1'b0;
    logic wdt_rst_o, to_flag_o;

    int n_chk = 0, n_bad = 0;
    int ecount, first_pulse, last_pulse, pulse_cnt;

    // bench reference state
    int   m_pre, m_post;
    logic m_pa, m_pb, m_flag, m_pulse;
    logic [1:0] m_src, m_range;
    logic m_dual;

    watchdog_timer #(.PRE_BITS(PB)) dut (
        .clk(clk), .rst(rst), .rc_tick(rc_tick), .instr_tick(instr_tick),
        .cfg_src(cfg_src), .cfg_range(cfg_range), .cfg_dual(cfg_dual),
        .clr_a(clr_a), .clr_b(clr_b), .wdt_rst_o(wdt_rst_o), .to_flag_o(to_flag_o)
    );

    always #2 clk = ~clk;

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #800000;
        n_bad++; n_chk++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    function automatic int wraps(input logic [1:0] r);
        return 1 << (int'(r) + 1);
    endfunction

    task automatic do_reset(input logic [1:0] s, input logic [1:0] r, input logic d);
        @(negedge clk);
        rst = 1'b1; cfg_src = s; cfg_range = r; cfg_dual = d;
        clr_a = 1'b0; clr_b = 1'b0; rc_tick = 1'b0; instr_tick = 1'b0;
        @(posedge clk); #1;
        check(wdt_rst_o == 1'b0 && to_flag_o == 1'b0, "R1 reset outputs",
              {wdt_rst_o, to_flag_o}, 0);
        m_pre = 0; m_post = 0; m_pa = 0; m_pb = 0; m_flag = 0; m_pulse = 0;
        m_src = s; m_range = r; m_dual = d;
        ecount = 0; first_pulse = -1; last_pulse = -1; pulse_cnt = 0;
    endtask

    // one cycle: drive, advance the reference, compare after the edge
    task automatic step(input logic a, input logic b, input logic rt, input logic it,
                        input string tag);
        logic tick, wrap, go;
        @(negedge clk);
        rst = 1'b0; clr_a = a; clr_b = b; rc_tick = rt; instr_tick = it;
        tick = (m_src == 2'd1) ? rt : (m_src == 2'd2) ? it : 1'b0;
        wrap = tick && (m_pre == PMOD - 1);
        go   = m_dual ? ((a | m_pa) & (b | m_pb)) : (a | b);
        if (tick) m_pre = (m_pre + 1) % PMOD;
        m_pulse = 1'b0;
        if (go) m_post = 0;
        else if (wrap) begin
            if (m_post == wraps(m_range) - 1) begin
                m_post = 0; m_pulse = 1'b1; m_flag = 1'b1;
            end else m_post++;
        end
        if (!m_dual || go) begin m_pa = 0; m_pb = 0; end
        else begin m_pa = m_pa | a; m_pb = m_pb | b; end
        @(posedge clk); #1;
        ecount++;
        if (wdt_rst_o) begin
            pulse_cnt++; last_pulse = ecount;
            if (first_pulse < 0) first_pulse = ecount;
        end
        check(wdt_rst_o == m_pulse && to_flag_o == m_flag, tag,
              {wdt_rst_o, to_flag_o}, {m_pulse, m_flag});
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);

        // R3, R4, R5: steady RC ticks, every range
        for (int r = 0; r < 4; r++) begin
            do_reset(2'd1, 2'(r), 1'b0);
            for (int k = 1; k <= 2 * wraps(2'(r)) * PMOD + 3; k++) step(0, 0, 1, 0, "R3 steady");
            check(first_pulse == wraps(2'(r)) * PMOD, "R3 first time-out", first_pulse, wraps(2'(r)) * PMOD);
            check(pulse_cnt == 2 && last_pulse == 2 * wraps(2'(r)) * PMOD, "R4 one-cycle repeat",
                  last_pulse, 2 * wraps(2'(r)) * PMOD);
            check(to_flag_o == 1'b1, "R5 flag sticky", to_flag_o, 1);
        end

        // R2: instruction source counts only instruction ticks
        do_reset(2'd2, 2'd0, 1'b0);
        for (int k = 1; k <= 40; k++) step(0, 0, 0, 1, "R2 instr");
        check(first_pulse == 32, "R2 instr source", first_pulse, 32);
        do_reset(2'd1, 2'd0, 1'b0);
        for (int k = 1; k <= 200; k++) step(0, 0, 0, 1, "R2 wrong source");
        check(pulse_cnt == 0, "R2 unselected tick ignored", pulse_cnt, 0);
        for (int s = 0; s < 4; s += 3) begin
            do_reset(2'(s), 2'd0, 1'b0);
            for (int k = 1; k <= 300; k++) step(0, 0, 1, 1, "R2 disabled");
            check(pulse_cnt == 0 && to_flag_o == 0, "R2 disabled never times out", pulse_cnt, 0);
        end

        // R6, R9: single clear at tick 20 moves time-out to 48, not 52
        do_reset(2'd1, 2'd0, 1'b0);
        for (int k = 1; k <= 60; k++) step(0, k == 20, 1, 0, "R6 single");
        check(first_pulse == 48, "R6 R9 clear keeps prescaler phase", first_pulse, 48);

        // R7: repeated lone strobe does nothing
        do_reset(2'd1, 2'd0, 1'b1);
        for (int k = 1; k <= 40; k++) step(k == 20 || k == 22, 0, 1, 0, "R7 lone");
        check(first_pulse == 32, "R7 lone strobe ignored", first_pulse, 32);

        // R7, R8: a@20 b@24 clears; lone b@40 must not clear again
        do_reset(2'd1, 2'd0, 1'b1);
        for (int k = 1; k <= 70; k++) step(k == 20, k == 24 || k == 40, 1, 0, "R8 handshake");
        check(first_pulse == 48, "R7 R8 handshake then stale strobe", first_pulse, 48);

        // R10: clear coincides with the final wrap at 32
        do_reset(2'd1, 2'd0, 1'b0);
        for (int k = 1; k <= 70; k++) step(k == 32, 0, 1, 0, "R10 tie");
        check(first_pulse == 64, "R10 clear wins over wrap", first_pulse, 64);

        // R11: configuration changes after reset are ignored
        do_reset(2'd1, 2'd0, 1'b0);
        cfg_src = 2'd0; cfg_range = 2'd3; cfg_dual = 1'b1;
        for (int k = 1; k <= 60; k++) step(k == 20, 0, 1, 0, "R11 cfg");
        check(first_pulse == 48, "R11 captured configuration kept", first_pulse, 48);

        // random episodes against the reference
        for (int e = 0; e < 8; e++) begin
            do_reset(2'($urandom % 4), 2'($urandom % 4), 1'($urandom % 2));
            for (int k = 1; k <= 1500; k++)
                step(($urandom % 150) == 0, ($urandom % 150) == 0,
                     ($urandom % 4) != 0, ($urandom % 3) != 0, "R2-R10 random");
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule